// File: doc/BRIEF.md
# Byte/Word Data Access Aligner

This block sits between a 16-bit register file and a byte-addressed data memory that is organised as 16-bit words. On each cycle in which an access is valid, it turns the operation code, the byte address and the operands into memory strobes and a register write-back value. All of this is combinational, so a load or store completes in the cycle it is presented. Byte stores are steered onto the proper lane. Byte loads are merged into the low byte of the destination register. The block also performs in-register sign and zero extension of the low byte.

A word access at an odd byte address is treated as a fault, but the instruction is not cancelled. A faulting read still returns data and updates the register. A faulting write completes as an instruction, but no memory write strobe is produced. In both cases an address-error trap request is registered for the following cycle. The request carries the faulting address and a flag that tells a read from a write. Trap vectoring, decode and the memory array lie outside the block.

Top module: `data_access_aligner`

## Requirements
- R1: `mem_addr` is `acc_addr` with bit 0 cleared. A byte load at an even address takes `mem_rdata[7:0]`, and a byte load at an odd address takes `mem_rdata[15:8]`.
- R2: A byte load (op code 1) asserts `reg_we`. `reg_wdata[15:8]` equals `reg_old[15:8]`, and the loaded byte lands in `reg_wdata[7:0]`.
- R3: A byte store (op code 3) asserts `mem_we`. It drives `mem_be` = 2'b01 at an even address and 2'b10 at an odd address, and it places `st_data[7:0]` on both halves of `mem_wdata`.
- R4: An aligned word store (op code 4) asserts `mem_we` with `mem_be` = 2'b11 and `mem_wdata` = `st_data`. An aligned word load (op code 2) writes `mem_rdata` to the register.
- R5: A word store at an odd address drives `mem_we` = 0 and `mem_be` = 2'b00, so memory is left unchanged.
- R6: A word load at an odd address still asserts `reg_we`, with `reg_wdata` equal to the word at the address with bit 0 cleared.
- R7: One cycle after a word access at an odd address, `trap_req` is 1 for that cycle. In the same cycle, `trap_addr` holds the faulting address and `trap_is_write` is 1 for a store and 0 for a load.
- R8: Byte accesses at any address, aligned word accesses and extend operations leave `trap_req` at 0 in the following cycle.
- R9: Sign extend (op code 5) writes `{8{reg_old[7]}, reg_old[7:0]}`.
- R10: Zero extend (op code 6) writes `{8'h00, reg_old[7:0]}`.
- R11: While `rst_n` is low at a clock edge, `trap_req`, `trap_addr` and `trap_is_write` are cleared.
- R12: With `acc_valid` low, or with op code 0 or 7, `mem_we`, `mem_be` and `reg_we` are all 0 and no trap follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_op | input | 3 | 0 none, 1 byte load, 2 word load, 3 byte store, 4 word store, 5 sign extend, 6 zero extend |
| acc_addr | input | 16 | Byte address of the access |
| reg_old | input | 16 | Current value of the destination/source register |
| st_data | input | 16 | Register value to store |
| mem_rdata | input | 16 | Word read from memory at `mem_addr` |
| mem_addr | output | 16 | Word-aligned memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 2 | Byte enables, bit 0 = low byte |
| mem_wdata | output | 16 | Memory write data |
| reg_we | output | 1 | Register write strobe |
| reg_wdata | output | 16 | Register write-back value |
| trap_req | output | 1 | Address-error trap pulse |
| trap_addr | output | 16 | Address of the faulting access |
| trap_is_write | output | 1 | Faulting access was a store |

## Verification
Memory strobes, write data and the register write-back value are combinational, so each is due in the same cycle its access is driven. The trap pulse, address and direction flag pass through one register and are due one clock later. The scoreboard therefore keeps two queues. Strobe and write-back expectations are compared in the same cycle they are driven. Trap expectations are held back and compared one cycle later. All sampling happens two time units after the falling edge, which is where the driver changes inputs.

// File: rtl/dal_pkg.sv
// Package: shared operation codes and helpers for the data access aligner.
// Assumes the data word is a whole number of bytes, at least two.
package dal_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LDB   = 3'd1,
        OP_LDW   = 3'd2,
        OP_STB   = 3'd3,
        OP_STW   = 3'd4,
        OP_SEXT  = 3'd5,
        OP_ZEXT  = 3'd6,
        OP_RSVD  = 3'd7
    } dal_op_e;

    // True for operations that move a full word to or from memory.
    function automatic logic is_word_op(dal_op_e op);
        return (op == OP_LDW) || (op == OP_STW);
    endfunction

endpackage

// File: rtl/dal_store_lane.sv
// Store lane steering: turns a store request into write strobe, byte
// enables and lane-replicated write data. Assumes DW is a multiple of 8.
// A misaligned word store yields no strobe and no enables.
module dal_store_lane
    import dal_pkg::*;
#(
    parameter int DW    = 16,
    parameter int LANES = DW / 8,
    parameter int LSB_W = $clog2(LANES)
) (
    input  logic             valid,
    input  dal_op_e          op,
    input  logic [LSB_W-1:0] lane,
    input  logic [DW-1:0]    st_data,
    output logic             mem_we,
    output logic [LANES-1:0] mem_be,
    output logic [DW-1:0]    mem_wdata
);

    logic is_stb;
    logic is_stw_ok;

    // Decode which kind of store, if any, is active.
    always_comb begin
        is_stb    = valid && (op == OP_STB);
        is_stw_ok = valid && (op == OP_STW) && (lane == '0);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per-lane enable and data: byte stores copy the low byte everywhere.
        always_comb begin
            mem_be[g]           = is_stw_ok || (is_stb && (lane == LSB_W'(g)));
            mem_wdata[g*8 +: 8] = (op == OP_STB) ? st_data[7:0] : st_data[g*8 +: 8];
        end
    end

    // Any enabled lane means memory is written.
    always_comb mem_we = |mem_be;

endmodule

// File: rtl/dal_load_merge.sv
// Load merge and extend: builds the register write-back value for byte
// and word loads and for in-register sign/zero extension of the low byte.
// A misaligned word load still returns the word at the aligned address.
module dal_load_merge
    import dal_pkg::*;
#(
    parameter int DW    = 16,
    parameter int LANES = DW / 8,
    parameter int LSB_W = $clog2(LANES)
) (
    input  logic             valid,
    input  dal_op_e          op,
    input  logic [LSB_W-1:0] lane,
    input  logic [DW-1:0]    mem_rdata,
    input  logic [DW-1:0]    reg_old,
    output logic             reg_we,
    output logic [DW-1:0]    reg_wdata
);

    logic [7:0] sel_byte;

    // Pick the addressed byte lane out of the memory word.
    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane == LSB_W'(i)) sel_byte = mem_rdata[i*8 +: 8];
        end
    end

    // Form the write-back value for each register-writing operation.
    always_comb begin
        reg_we    = 1'b0;
        reg_wdata = reg_old;
        if (valid) begin
            unique case (op)
                OP_LDB:  begin reg_we = 1'b1; reg_wdata = {reg_old[DW-1:8], sel_byte}; end
                OP_LDW:  begin reg_we = 1'b1; reg_wdata = mem_rdata; end
                OP_SEXT: begin reg_we = 1'b1; reg_wdata = {{(DW-8){reg_old[7]}}, reg_old[7:0]}; end
                OP_ZEXT: begin reg_we = 1'b1; reg_wdata = {{(DW-8){1'b0}}, reg_old[7:0]}; end
                default: begin reg_we = 1'b0; reg_wdata = reg_old; end
            endcase
        end
    end

endmodule

// File: rtl/dal_trap_reg.sv
// Trap register: flags a word access at a non-word-aligned address and
// presents a one-cycle trap pulse with the faulting address and direction
// on the next clock. Address and flag hold until the next fault.
module dal_trap_reg
    import dal_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LSB_W = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  dal_op_e       op,
    input  logic [AW-1:0] addr,
    output logic          trap_req,
    output logic [AW-1:0] trap_addr,
    output logic          trap_is_write
);

    logic fault;

    // A fault is a valid word access with any in-word offset bit set.
    always_comb fault = valid && is_word_op(op) && (addr[LSB_W-1:0] != '0);

    // Register the pulse and capture the faulting access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_req      <= 1'b0;
            trap_addr     <= '0;
            trap_is_write <= 1'b0;
        end else begin
            trap_req <= fault;
            if (fault) begin
                trap_addr     <= addr;
                trap_is_write <= (op == OP_STW);
            end
        end
    end

endmodule

// File: rtl/data_access_aligner.sv
// Top: byte/word data access aligner between a register file and a
// byte-addressed word memory. Loads, stores and extends complete in the
// cycle presented; misaligned word accesses raise a trap one cycle later.
// Assumes memory returns mem_rdata combinationally for mem_addr.
module data_access_aligner
    import dal_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic [2:0]      acc_op,
    input  logic [AW-1:0]   acc_addr,
    input  logic [DW-1:0]   reg_old,
    input  logic [DW-1:0]   st_data,
    input  logic [DW-1:0]   mem_rdata,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0]   mem_wdata,
    output logic            reg_we,
    output logic [DW-1:0]   reg_wdata,
    output logic            trap_req,
    output logic [AW-1:0]   trap_addr,
    output logic            trap_is_write
);

    localparam int LANES = DW / 8;
    localparam int LSB_W = $clog2(LANES);

    dal_op_e          op;
    logic [LSB_W-1:0] lane;

    // Decode operation and in-word byte offset; align the memory address.
    always_comb begin
        op       = dal_op_e'(acc_op);
        lane     = acc_addr[LSB_W-1:0];
        mem_addr = {acc_addr[AW-1:LSB_W], {LSB_W{1'b0}}};
    end

    dal_store_lane #(.DW(DW), .LANES(LANES), .LSB_W(LSB_W)) u_store (
        .valid     (acc_valid),
        .op        (op),
        .lane      (lane),
        .st_data   (st_data),
        .mem_we    (mem_we),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata)
    );

    dal_load_merge #(.DW(DW), .LANES(LANES), .LSB_W(LSB_W)) u_load (
        .valid     (acc_valid),
        .op        (op),
        .lane      (lane),
        .mem_rdata (mem_rdata),
        .reg_old   (reg_old),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata)
    );

    dal_trap_reg #(.AW(AW), .LSB_W(LSB_W)) u_trap (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid         (acc_valid),
        .op            (op),
        .addr          (acc_addr),
        .trap_req      (trap_req),
        .trap_addr     (trap_addr),
        .trap_is_write (trap_is_write)
    );

endmodule

// File: rtl/dal_checker.sv
// Checker: temporal properties of the data access aligner at its ports.
// Bound into every instance of the top module.
module dal_checker #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic [2:0]      acc_op,
    input logic [AW-1:0]   acc_addr,
    input logic [DW-1:0]   reg_old,
    input logic            mem_we,
    input logic [DW/8-1:0] mem_be,
    input logic            reg_we,
    input logic [DW-1:0]   reg_wdata,
    input logic            trap_req,
    input logic [AW-1:0]   trap_addr,
    input logic            trap_is_write
);

    logic odd_word;
    always_comb odd_word = acc_valid && (acc_op == 3'd2 || acc_op == 3'd4) && acc_addr[0];

    // R5
    misal_store_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == 3'd4 && acc_addr[0]) |-> (!mem_we && mem_be == '0));

    // R7
    trap_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && odd_word) |=> (trap_req && trap_addr == $past(acc_addr)
                                 && trap_is_write == ($past(acc_op) == 3'd4)));

    // R8
    no_spurious_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !odd_word |=> !trap_req);

    // R3
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == 3'd3) |-> ($countones(mem_be) == 1 && mem_be[acc_addr[0]]));

    // R2
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == 3'd1) |-> (reg_we && reg_wdata[DW-1:8] == reg_old[DW-1:8]));

    // R9
    sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == 3'd5) |-> (reg_wdata[DW-1:8] == {(DW-8){reg_old[7]}}));

endmodule

bind data_access_aligner dal_checker #(.AW(AW), .DW(DW)) u_dal_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_op        (acc_op),
    .acc_addr      (acc_addr),
    .reg_old       (reg_old),
    .mem_we        (mem_we),
    .mem_be        (mem_be),
    .reg_we        (reg_we),
    .reg_wdata     (reg_wdata),
    .trap_req      (trap_req),
    .trap_addr     (trap_addr),
    .trap_is_write (trap_is_write)
);

// File: tb/tb_data_access_aligner.sv
// Scoreboard bench: a driver task applies one access per cycle and queues
// the expected same-cycle outputs and the expected trap one cycle later;
// a monitor pops and compares both streams.
module tb_data_access_aligner;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_op = 3'd0;
    logic [15:0] acc_addr = '0;
    logic [15:0] reg_old = '0;
    logic [15:0] st_data = '0;
    logic [15:0] mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic        reg_we;
    logic [15:0] reg_wdata;
    logic        trap_req;
    logic [15:0] trap_addr;
    logic        trap_is_write;

    int tests = 0;
    int fails = 0;

    logic [15:0] mem [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    data_access_aligner dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_op(acc_op),
        .acc_addr(acc_addr), .reg_old(reg_old), .st_data(st_data),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .trap_req(trap_req), .trap_addr(trap_addr),
        .trap_is_write(trap_is_write)
    );

    // Memory model: combinational read, byte-enabled write on the clock.
    assign mem_rdata = mem[mem_addr[8:1]];
    always @(posedge clk) begin
        if (mem_we) begin
            if (mem_be[0]) mem[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
        end
    end

    typedef struct {
        string       req;
        logic        valid;
        logic        we;
        logic [1:0]  be;
        logic [15:0] wdata;
        logic [15:0] maddr;
        logic        rwe;
        logic [15:0] rdata;
    } comb_t;

    typedef struct {
        string       req;
        logic        pulse;
        logic [15:0] addr;
        logic        wr;
    } trap_t;

    comb_t comb_q[$];
    trap_t trap_q[$];

    task automatic fail_line(string req, string what, logic [31:0] act, logic [31:0] exp);
        fails++;
        $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    endtask

    // Driver: apply one access at the falling edge and queue expectations.
    task automatic acc(input logic v, input logic [2:0] op, input logic [15:0] a,
                       input logic [15:0] old, input logic [15:0] sd, input string req);
        comb_t c;
        trap_t t;
        logic [15:0] word;
        @(negedge clk);
        acc_valid = v; acc_op = op; acc_addr = a; reg_old = old; st_data = sd;
        word = mem[a[8:1]];
        c.req = req; c.valid = v; c.we = 0; c.be = 2'b00; c.wdata = '0;
        c.maddr = {a[15:1], 1'b0}; c.rwe = 0; c.rdata = '0;
        if (v) begin
            case (op)
                3'd1: begin c.rwe = 1; c.rdata = {old[15:8], a[0] ? word[15:8] : word[7:0]}; end
                3'd2: begin c.rwe = 1; c.rdata = word; end
                3'd3: begin c.we = 1; c.be = a[0] ? 2'b10 : 2'b01; c.wdata = {sd[7:0], sd[7:0]}; end
                3'd4: if (!a[0]) begin c.we = 1; c.be = 2'b11; c.wdata = sd; end
                3'd5: begin c.rwe = 1; c.rdata = {{8{old[7]}}, old[7:0]}; end
                3'd6: begin c.rwe = 1; c.rdata = {8'h00, old[7:0]}; end
                default: ;
            endcase
        end
        t.req = req;
        t.pulse = v && (op == 3'd2 || op == 3'd4) && a[0];
        t.addr = a;
        t.wr = (op == 3'd4);
        comb_q.push_back(c);
        trap_q.push_back(t);
    endtask

    // Monitor: same-cycle outputs now, trap outputs of the previous access.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (comb_q.size() > 0) begin
                comb_t c;
                c = comb_q.pop_front();
                tests++;
                if (mem_we !== c.we) fail_line(c.req, "mem_we", 32'(mem_we), 32'(c.we));
                else if (mem_be !== c.be) fail_line(c.req, "mem_be", 32'(mem_be), 32'(c.be));
                else if (c.we && mem_wdata !== c.wdata) fail_line(c.req, "mem_wdata", 32'(mem_wdata), 32'(c.wdata));
                else if (reg_we !== c.rwe) fail_line(c.req, "reg_we", 32'(reg_we), 32'(c.rwe));
                else if (c.rwe && reg_wdata !== c.rdata) fail_line(c.req, "reg_wdata", 32'(reg_wdata), 32'(c.rdata));
                else if (c.valid && mem_addr !== c.maddr) fail_line(c.req, "mem_addr", 32'(mem_addr), 32'(c.maddr));
            end
            if (trap_q.size() >= 2) begin
                trap_t t;
                t = trap_q.pop_front();
                tests++;
                if (trap_req !== t.pulse) fail_line(t.req, "trap_req", 32'(trap_req), 32'(t.pulse));
                else if (t.pulse && trap_addr !== t.addr) fail_line(t.req, "trap_addr", 32'(trap_addr), 32'(t.addr));
                else if (t.pulse && trap_is_write !== t.wr) fail_line(t.req, "trap_is_write", 32'(trap_is_write), 32'(t.wr));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101) ^ 16'hA5C3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: trap state cleared by reset
        tests++;
        if ({trap_req, trap_addr, trap_is_write} !== 18'd0)
            fail_line("R11", "trap state", 32'({trap_req, trap_addr, trap_is_write}), 32'd0);
        rst_n = 1'b1;

        acc(1, 3'd1, 16'h0010, 16'h7E00, 16'h0, "R1_R2 byte load even");
        acc(1, 3'd1, 16'h0011, 16'h1B22, 16'h0, "R1_R2 byte load odd");
        acc(1, 3'd2, 16'h0020, 16'h0000, 16'h0, "R4 word load aligned");
        acc(1, 3'd3, 16'h0030, 16'h0000, 16'h1234, "R3 byte store even");
        acc(1, 3'd3, 16'h0031, 16'h0000, 16'hABCD, "R3 byte store odd");
        acc(1, 3'd2, 16'h0030, 16'h0000, 16'h0, "R3 readback");
        acc(1, 3'd4, 16'h0040, 16'h0000, 16'hBEEF, "R4 word store aligned");
        acc(1, 3'd2, 16'h0040, 16'h0000, 16'h0, "R4 readback");
        acc(1, 3'd4, 16'h0043, 16'h0000, 16'h5555, "R5_R7 misaligned store");
        acc(1, 3'd2, 16'h0042, 16'h0000, 16'h0, "R5 memory unchanged");
        acc(1, 3'd2, 16'h0051, 16'h0000, 16'h0, "R6_R7 misaligned load");
        acc(1, 3'd4, 16'h0061, 16'h0000, 16'h9999, "R7 back-to-back store");
        acc(1, 3'd2, 16'h0063, 16'h0000, 16'h0, "R7 back-to-back load");
        acc(1, 3'd1, 16'h0071, 16'hC3C3, 16'h0, "R8 odd byte load no trap");
        acc(1, 3'd3, 16'h0073, 16'h0000, 16'h00EE, "R8 odd byte store no trap");
        acc(1, 3'd5, 16'h0001, 16'h1280, 16'h0, "R9 sext negative");
        acc(1, 3'd5, 16'h0001, 16'h347F, 16'h0, "R9 sext positive");
        acc(1, 3'd6, 16'h0001, 16'hFF9A, 16'h0, "R10 zext");
        acc(1, 3'd0, 16'h0081, 16'h0000, 16'h7777, "R12 op none");
        acc(1, 3'd7, 16'h0083, 16'h0000, 16'h7777, "R12 reserved op");
        acc(0, 3'd4, 16'h0085, 16'h0000, 16'h7777, "R12 invalid store");
        acc(1, 3'd2, 16'h0084, 16'h0000, 16'h0, "R12 readback");
        acc(0, 3'd0, 16'h0000, 16'h0000, 16'h0, "idle flush");
        acc(0, 3'd0, 16'h0000, 16'h0000, 16'h0, "idle flush");
        @(negedge clk);
        #4;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule